// File: doc/BRIEF.md
# Programmable UART with status registers

This block is an asynchronous serial transmitter and receiver that a processor reaches through a small read/write register bus. Software sets the frame shape at run time: five to eight data bits, parity off, even or odd, and a stop period of one, one and a half or two bit times. The baud rate comes from a clock divisor, and every bit lasts sixteen divided ticks.

To send, software writes a character to the data register and then writes 1 to the transmit status register. The transmitter keeps that status at 1 for the whole frame and drops it to 0 when the stop period ends. The receiver waits for a falling edge on the line. It checks the start bit at its midpoint, then samples each data bit and any parity bit at mid-bit, and finally samples the stop bit. It then stores the character, sets the receive status, and records any parity or framing fault. Software reads the data and writes 0 to the receive status to clear it. Each direction has an interrupt request with its own enable bit.

Top module: `uart_core`

## Requirements
- R1: After reset, txLine is 1. Transmit status (address 1) and receive status (address 2) read 0x00. Config (address 3) reads 0x03. Divisor (address 4) reads 0x00. Both interrupt outputs are 0.
- R2: A transmitted frame is a low start bit, then the data bits from bit 0 upward, then the stop period at 1. The data bit count is 5 plus config bits [1:0] (00 gives 5 and 11 gives 8). Between frames the line stays at 1.
- R3: When config bit 2 is 1, a parity bit follows the last data bit. Config bit 3 chooses odd parity (1) or even parity (0), counted over the data bits and the parity bit together.
- R4: Config bits [5:4] set the stop period: 00 is 16 ticks, 01 is 24 ticks, 10 and 11 are 32 ticks. With divisor 0, transmit status bit 0 returns to 0 exactly 16*(1+bits+parity)+stop clocks after the write that started the frame.
- R5: Writing address 1 with bit 0 set starts a frame. Transmit status bit 0 then reads 1 until the frame ends. txIrq equals config bit 6 AND NOT busy.
- R6: A received frame, decoded with the same config fields, puts its data bits zero-extended into address 0 and sets receive status bit 0.
- R7: When parity is enabled, a received parity bit that breaks the selected parity sets receive status bit 1. The data is still stored.
- R8: A stop sample taken at 0 sets receive status bit 2.
- R9: Writing address 2 with bit 0 at 0 clears receive status bits 0, 1 and 2. Writing address 2 with bit 0 at 1 leaves them unchanged.
- R10: rxIrq equals config bit 7 AND receive status bit 0.
- R11: A low pulse on rxLine that has ended by the start-bit midpoint check (8 ticks) is dropped. Receive status stays 0.
- R12: The divisor register (address 4) makes the sample tick occur every divisor+1 clocks. A bit then lasts 16*(divisor+1) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr (combinational) |
| rxLine | input | 1 | Serial input |
| txLine | output | 1 | Serial output |
| txIrq | output | 1 | Transmitter idle interrupt request |
| rxIrq | output | 1 | Character available interrupt request |

## Verification
A tick or bit counter that is off by one shows up in the transmit busy time. That time is measured to the exact clock, so the error appears when the first frame ends. A bit counter that ends the frame in the wrong place shifts the decoded frame on txLine or the character read back from address 0. A wrong sampling phase in the receiver corrupts the stored data, or it raises parity or framing errors on clean frames. These faults show in the status read that follows the frame, a few clocks after the stop sample. A flag that sticks or clears at the wrong time shows at once on the interrupt outputs and on the next status read.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int FRAME_W = DATA_W + 2;

  localparam logic [ADDR_W-1:0] ADDR_DATA   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_TXSTAT = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_RXSTAT = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CFG    = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_DIV    = 3'd4;

  // Config byte layout, most significant field first
  typedef struct packed {
    logic       rxIrqEn;
    logic       txIrqEn;
    logic [1:0] stopSel;
    logic       parOdd;
    logic       parEn;
    logic [1:0] lenSel;
  } cfgT;

  // Strobes from control to datapath
  typedef struct packed {
    logic txLoad;
    logic txShift;
    logic txDone;
    logic rxCapture;
    logic rxDone;
  } strobeT;

  typedef enum logic [1:0] {TX_IDLE, TX_BITS, TX_STOP} txStateT;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rxStateT;

  function automatic logic [3:0] lenOf(logic [1:0] sel);
    return 4'd5 + {2'b00, sel};
  endfunction
endpackage

// File: rtl/uart_control.sv
module uart_control
  import uart_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       txGo,
  input  logic       rxIn,
  input  logic [1:0] lenSel,
  input  logic       parEn,
  input  logic [1:0] stopSel,
  output strobeT     strb
);
  localparam int CNT_W = $clog2(2 * OVERSAMPLE);
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVERSAMPLE / 2 - 1);

  txStateT txState;
  rxStateT rxState;
  logic [CNT_W-1:0] txTick, rxTick, stopLast;
  logic [3:0] txBit, rxBit, txFrameLast, rxBitsLast;

  assign txFrameLast = lenOf(lenSel) + {3'b000, parEn};
  assign rxBitsLast  = lenOf(lenSel) + {3'b000, parEn} - 4'd1;

  always_comb begin
    case (stopSel)
      2'd0:    stopLast = CNT_W'(OVERSAMPLE - 1);
      2'd1:    stopLast = CNT_W'(OVERSAMPLE + OVERSAMPLE / 2 - 1);
      default: stopLast = CNT_W'(2 * OVERSAMPLE - 1);
    endcase
  end

  always_comb begin
    strb = '0;
    strb.txLoad    = (txState == TX_IDLE) && txGo;
    strb.txShift   = tick && (txState == TX_BITS) && (txTick == BIT_LAST);
    strb.txDone    = tick && (txState == TX_STOP) && (txTick == stopLast);
    strb.rxCapture = tick && (rxState == RX_BITS) && (rxTick == BIT_LAST);
    strb.rxDone    = tick && (rxState == RX_STOP) && (rxTick == BIT_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      txTick  <= '0;
      txBit   <= '0;
    end else begin
      case (txState)
        TX_IDLE: if (txGo) begin
          txState <= TX_BITS;
          txTick  <= '0;
          txBit   <= '0;
        end
        TX_BITS: if (tick) begin
          if (txTick == BIT_LAST) begin
            txTick <= '0;
            if (txBit == txFrameLast) txState <= TX_STOP;
            else txBit <= txBit + 4'd1;
          end else txTick <= txTick + 1'b1;
        end
        default: if (tick) begin
          if (txTick == stopLast) txState <= TX_IDLE;
          else txTick <= txTick + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxTick  <= '0;
      rxBit   <= '0;
    end else if (tick) begin
      case (rxState)
        RX_IDLE: if (!rxIn) begin
          rxState <= RX_START;
          rxTick  <= '0;
        end
        RX_START: begin
          if (rxTick == HALF_LAST) begin
            rxTick  <= '0;
            rxBit   <= '0;
            rxState <= rxIn ? RX_IDLE : RX_BITS;
          end else rxTick <= rxTick + 1'b1;
        end
        RX_BITS: begin
          if (rxTick == BIT_LAST) begin
            rxTick <= '0;
            if (rxBit == rxBitsLast) rxState <= RX_STOP;
            else rxBit <= rxBit + 4'd1;
          end else rxTick <= rxTick + 1'b1;
        end
        default: begin
          if (rxTick == BIT_LAST) rxState <= RX_IDLE;
          else rxTick <= rxTick + 1'b1;
        end
      endcase
    end
  end

  // A start request from the register side must only arrive while the transmitter is idle
  assert_go_when_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    txGo |-> (txState == TX_IDLE));
endmodule

// File: rtl/uart_datapath.sv
module uart_datapath
  import uart_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter logic [DIV_W-1:0] DIV_RESET = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rxLine,
  output logic              txLine,
  output logic              txIrq,
  output logic              rxIrq,
  input  strobeT            strb,
  output logic              tick,
  output logic              txGo,
  output logic              rxIn,
  output cfgT               cfg
);
  logic [DIV_W-1:0] divReg, divCnt;
  logic [DATA_W-1:0] txData, rxData, txMasked, rxMasked;
  logic [FRAME_W-1:0] txShreg, txFrame;
  logic [DATA_W:0] rxShreg, rxAligned;
  logic [3:0] dataLen, rxCount;
  logic txBusy, rxReady, rxParErr, rxFrmErr, txPar, rxParBad;
  logic [1:0] rxSync;

  assign dataLen = lenOf(cfg.lenSel);
  assign rxCount = dataLen + {3'b000, cfg.parEn};
  assign tick    = (divCnt == '0);
  assign txGo    = busWr && (busAddr == ADDR_TXSTAT) && busWdata[0] && !txBusy;
  assign rxIn    = rxSync[1];
  assign txLine  = txShreg[0];
  assign txIrq   = cfg.txIrqEn && !txBusy;
  assign rxIrq   = cfg.rxIrqEn && rxReady;

  // Frame image: start bit, masked data, optional parity, ones above
  always_comb begin
    txMasked = '0;
    for (int i = 0; i < DATA_W; i++)
      if (i < int'(dataLen)) txMasked[i] = txData[i];
    txPar = (^txMasked) ^ cfg.parOdd;
    txFrame = '1;
    txFrame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < int'(dataLen)) txFrame[i+1] = txData[i];
    if (cfg.parEn) txFrame[dataLen + 4'd1] = txPar;
  end

  // Newest bits sit at the top of the shift register
  always_comb begin
    rxAligned = rxShreg >> (4'(DATA_W + 1) - rxCount);
    rxMasked = '0;
    for (int i = 0; i < DATA_W; i++)
      if (i < int'(dataLen)) rxMasked[i] = rxAligned[i];
    rxParBad = cfg.parEn && ((^rxMasked) ^ rxAligned[dataLen] ^ cfg.parOdd);
  end

  always_comb begin
    case (busAddr)
      ADDR_DATA:   busRdata = rxData;
      ADDR_TXSTAT: busRdata = {7'b0, txBusy};
      ADDR_RXSTAT: busRdata = {5'b0, rxFrmErr, rxParErr, rxReady};
      ADDR_CFG:    busRdata = cfg;
      ADDR_DIV:    busRdata = DATA_W'(divReg);
      default:     busRdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg     <= cfgT'(8'h03);
      divReg  <= DIV_RESET;
      divCnt  <= '0;
      txData  <= '0;
      txBusy  <= 1'b0;
      txShreg <= '1;
    end else begin
      if (busWr && busAddr == ADDR_CFG)  cfg    <= cfgT'(busWdata);
      if (busWr && busAddr == ADDR_DIV)  divReg <= DIV_W'(busWdata);
      if (busWr && busAddr == ADDR_DATA) txData <= busWdata;
      divCnt <= tick ? divReg : divCnt - 1'b1;
      if (txGo) txBusy <= 1'b1;
      else if (strb.txDone) txBusy <= 1'b0;
      if (strb.txLoad) txShreg <= txFrame;
      else if (strb.txShift) txShreg <= {1'b1, txShreg[FRAME_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSync   <= 2'b11;
      rxShreg  <= '0;
      rxData   <= '0;
      rxReady  <= 1'b0;
      rxParErr <= 1'b0;
      rxFrmErr <= 1'b0;
    end else begin
      rxSync <= {rxSync[0], rxLine};
      if (strb.rxCapture) rxShreg <= {rxIn, rxShreg[DATA_W:1]};
      if (strb.rxDone) begin
        rxData   <= rxMasked;
        rxReady  <= 1'b1;
        rxParErr <= rxParBad;
        rxFrmErr <= !rxIn;
      end else if (busWr && busAddr == ADDR_RXSTAT && !busWdata[0]) begin
        rxReady  <= 1'b0;
        rxParErr <= 1'b0;
        rxFrmErr <= 1'b0;
      end
    end
  end

  assert_idle_line_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txLine);
  assert_start_bit_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.txLoad |=> !txLine);
  assert_busy_ends_at_stop_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txBusy) |-> $past(strb.txDone));
  assert_ready_from_frame_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxReady) |-> $past(strb.rxDone));
endmodule

// File: rtl/uart_core.sv
module uart_core
  import uart_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DIV_W = 8,
  parameter logic [DIV_W-1:0] DIV_RESET = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rxLine,
  output logic              txLine,
  output logic              txIrq,
  output logic              rxIrq
);
  strobeT strb;
  cfgT cfg;
  logic tick, txGo, rxIn;

  uart_datapath #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_datapath (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .rxLine(rxLine), .txLine(txLine), .txIrq(txIrq), .rxIrq(rxIrq),
    .strb(strb), .tick(tick), .txGo(txGo), .rxIn(rxIn), .cfg(cfg)
  );

  uart_control #(.OVERSAMPLE(OVERSAMPLE)) u_control (
    .clk(clk), .rstN(rstN), .tick(tick), .txGo(txGo), .rxIn(rxIn),
    .lenSel(cfg.lenSel), .parEn(cfg.parEn), .stopSel(cfg.stopSel), .strb(strb)
  );
endmodule

// File: tb/uart_core_bench.sv
module uart_core_bench;
  logic clk = 1'b0, rstN = 1'b0, busWr = 1'b0, rxLine = 1'b1;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic txLine, txIrq, rxIrq;
  int checks = 0, fails = 0;
  bit finished = 0;

  typedef struct { logic [9:0] bits; int n; int period; } frameT;
  frameT expQ[$];

  uart_core u_uart_core (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .rxLine(rxLine), .txLine(txLine), .txIrq(txIrq), .rxIrq(rxIrq)
  );

  always #2 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkRange(string req, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic busWrite(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  function automatic logic [7:0] cfgByte(int lenSel, bit pe, bit odd, int stop, bit txEn, bit rxEn);
    return {rxEn, txEn, 2'(stop), odd, pe, 2'(lenSel)};
  endfunction

  function automatic logic [9:0] mkFrame(logic [7:0] d, int len, bit pe, bit odd, bit badPar);
    logic [9:0] f = '1;
    logic p = odd;
    f[0] = 1'b0;
    for (int i = 0; i < len; i++) begin
      f[i+1] = d[i];
      p ^= d[i];
    end
    if (pe) f[len+1] = p ^ badPar;
    return f;
  endfunction

  // Scoreboard monitor: decode every frame on txLine against the queue
  initial begin
    frameT f;
    logic [9:0] got;
    logic stopV;
    forever begin
      @(negedge txLine);
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 unexpected frame actual=1 expected=0");
      end else begin
        f = expQ.pop_front();
        got = '1;
        repeat (f.period / 2) @(negedge clk);
        got[0] = txLine;
        for (int k = 1; k < f.n; k++) begin
          repeat (f.period) @(negedge clk);
          got[k] = txLine;
        end
        repeat (f.period) @(negedge clk);
        stopV = txLine;
        check("R2/R3 frame bits", 32'(got), 32'(f.bits));
        check("R2 stop level", 32'(stopV), 1);
      end
    end
  end

  task automatic txSend(logic [7:0] d, int lenSel, bit pe, bit odd, int stop, int div);
    frameT f;
    int len = 5 + lenSel;
    int stopTicks = (stop == 0) ? 16 : (stop == 1) ? 24 : 32;
    int t;
    int cnt;
    f.bits = mkFrame(d, len, pe, odd, 1'b0);
    f.n = 1 + len + int'(pe);
    f.period = 16 * (div + 1);
    t = 16 * f.n + stopTicks;
    busWrite(3'd3, cfgByte(lenSel, pe, odd, stop, 1'b1, 1'b0));
    busWrite(3'd0, d);
    expQ.push_back(f);
    busWrite(3'd1, 8'h01);
    busAddr = 3'd1;
    #1;
    check("R5 busy after start", 32'(busRdata[0]), 1);
    check("R5 txIrq low while busy", 32'(txIrq), 0);
    cnt = 1;
    while (busRdata[0] === 1'b1 && cnt < 5000) begin
      @(negedge clk);
      cnt++;
      #1;
    end
    if (div == 0) check("R4 busy duration", 32'(cnt), 32'(t + 1));
    else checkRange("R12 busy duration with divisor", cnt, 2 * t - 1, 2 * t + 3);
    check("R5 txIrq high when idle", 32'(txIrq), 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic rxSend(logic [9:0] bits, int n, bit stopLow);
    for (int k = 0; k < n; k++) begin
      rxLine = bits[k];
      repeat (16) @(negedge clk);
    end
    rxLine = stopLow ? 1'b0 : 1'b1;
    repeat (stopLow ? 12 : 16) @(negedge clk);
    rxLine = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 txLine idle", 32'(txLine), 1);
    check("R1 txIrq", 32'(txIrq), 0);
    check("R1 rxIrq", 32'(rxIrq), 0);
    busRead(3'd1, r); check("R1 tx status", 32'(r), 0);
    busRead(3'd2, r); check("R1 rx status", 32'(r), 0);
    busRead(3'd3, r); check("R1 config", 32'(r), 32'h03);
    busRead(3'd4, r); check("R1 divisor", 32'(r), 0);

    // Transmit: R2 lengths, R3 parity, R4 stop lengths
    txSend(8'hA5, 3, 1'b0, 1'b0, 0, 0);
    txSend(8'h3B, 0, 1'b1, 1'b0, 1, 0);
    txSend(8'h55, 2, 1'b1, 1'b1, 2, 0);
    txSend(8'h2C, 1, 1'b0, 1'b0, 3, 0);

    // R12 divisor of 1 doubles the bit time
    busWrite(3'd4, 8'h01);
    busRead(3'd4, r); check("R12 divisor readback", 32'(r), 1);
    txSend(8'h96, 3, 1'b0, 1'b0, 0, 1);
    busWrite(3'd4, 8'h00);
    check("R2 expected frames consumed", 32'(expQ.size()), 0);

    // R6 and R10 receive a clean 8-bit frame
    busWrite(3'd3, cfgByte(3, 1'b0, 1'b0, 0, 1'b0, 1'b1));
    check("R10 rxIrq low before frame", 32'(rxIrq), 0);
    rxSend(mkFrame(8'h3C, 8, 1'b0, 1'b0, 1'b0), 9, 1'b0);
    busRead(3'd2, r); check("R6 rx status ready", 32'(r), 32'h01);
    busRead(3'd0, r); check("R6 rx data", 32'(r), 32'h3C);
    check("R10 rxIrq with ready", 32'(rxIrq), 1);

    // R9 writing 1 keeps flags, writing 0 clears them
    busWrite(3'd2, 8'h01);
    busRead(3'd2, r); check("R9 write of 1 ignored", 32'(r), 32'h01);
    busWrite(3'd2, 8'h00);
    busRead(3'd2, r); check("R9 write of 0 clears", 32'(r), 0);
    check("R10 rxIrq after clear", 32'(rxIrq), 0);

    // R7 parity error, data still stored
    busWrite(3'd3, cfgByte(3, 1'b1, 1'b0, 0, 1'b0, 1'b1));
    rxSend(mkFrame(8'hC3, 8, 1'b1, 1'b0, 1'b1), 10, 1'b0);
    busRead(3'd2, r); check("R7 parity error flag", 32'(r), 32'h03);
    busRead(3'd0, r); check("R7 data kept", 32'(r), 32'hC3);
    busWrite(3'd2, 8'h00);

    // R8 framing error
    busWrite(3'd3, cfgByte(3, 1'b0, 1'b0, 0, 1'b0, 1'b1));
    rxSend(mkFrame(8'h81, 8, 1'b0, 1'b0, 1'b0), 9, 1'b1);
    busRead(3'd2, r); check("R8 framing error flag", 32'(r), 32'h05);
    busWrite(3'd2, 8'h00);

    // R11 short low pulse rejected
    rxLine = 1'b0;
    repeat (4) @(negedge clk);
    rxLine = 1'b1;
    repeat (60) @(negedge clk);
    busRead(3'd2, r); check("R11 glitch ignored", 32'(r), 0);

    // R6 with R3: 5-bit odd parity, upper data bits zero
    busWrite(3'd3, cfgByte(0, 1'b1, 1'b1, 0, 1'b0, 1'b1));
    rxSend(mkFrame(8'hF6, 5, 1'b1, 1'b1, 1'b0), 7, 1'b0);
    busRead(3'd2, r); check("R3 odd parity accepted", 32'(r), 32'h01);
    busRead(3'd0, r); check("R6 short data zero-extended", 32'(r), 32'h16);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule